// File: doc/BRIEF.md
# Branch and Call Control Unit

This unit resolves control flow for an 8-bit processor core that has a 16-bit program counter and a stack growing toward lower addresses. The decode stage hands it one already-classified request. The request carries the operation kind, the opcode byte, a 16-bit immediate, an 8-bit displacement, the program counter already advanced past the operands, the stack pointer, the HL pair, and the zero and carry flags. The unit decides whether the branch is taken and produces the next program counter and stack pointer. It also charges the machine cycles that the operation costs. For calls, restarts and returns it moves the 16-bit return address through a byte-wide memory port, one byte per transfer.

The request side is a valid/ready handshake. The producer raises `req_valid` and must hold every request field stable until a cycle in which `req_ready` is also high. `req_ready` is high only while the unit is idle, so at most one request is in flight. The memory side is also valid/ready. While `mem_valid` is high and `mem_ready` is low, the unit keeps `mem_addr`, `mem_we` and `mem_wdata` stable. Read data is taken from `mem_rdata` in the cycle in which `mem_ready` is high. Completion is a one-cycle `done` pulse. The results are valid only in that cycle, and the unit is idle again in the next cycle.

Top module: `flow_ctl`

## Requirements
- R1: For conditional absolute jumps, relative jumps, calls and returns with `req_cond_en`=1, the branch is taken when opcode bits 4:3 select a flag state that matches: 0 taken if Z=0, 1 taken if Z=1, 2 taken if C=0, 3 taken if C=1. With `req_cond_en`=0 these kinds are always taken. `taken` reports the outcome at `done`.
- R2: Absolute jump (kind 0): when taken, next PC is the immediate and the cost is 4 cycles. When not taken, next PC is the request PC and the cost is 3 cycles. SP is unchanged.
- R3: Relative jump (kind 1): when taken, next PC is the request PC plus the sign-extended 8-bit displacement, modulo 2^16, at a cost of 3 cycles. When not taken, next PC is the request PC and the cost is 2 cycles.
- R4: Call (kind 2): when taken, the unit writes the request PC high byte at SP-1 and then the low byte at SP-2. Next SP is SP-2, next PC is the immediate, and the cost is 6 cycles. When not taken, the cost is 3 cycles, no memory access is made, and PC and SP are unchanged.
- R5: Return (kind 3): when taken, the unit reads the low byte at SP and the high byte at SP+1. Next PC is {high, low} and next SP is SP+2. The cost is 5 cycles if conditional and taken, 4 cycles if unconditional, and 2 cycles when not taken with no memory access.
- R6: Return-from-interrupt (kind 4) always behaves as an unconditional return costing 4 cycles, ignoring the condition inputs. `ime_set` is high in the `done` cycle and at no other time.
- R7: Restart (kind 5) ignores the condition inputs and pushes like a taken call. Next PC is the opcode AND 0x38, zero-extended, and the cost is 4 cycles.
- R8: Jump-to-HL (kind 6) sets next PC to HL, leaves SP unchanged and costs 1 cycle.
- R9: `req_ready` is high only when idle. `done` lasts exactly one cycle and `req_ready` returns in the next cycle. A request that needs no memory access raises `done` in the cycle after it is accepted.
- R10: A memory request holds `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ready`. Each byte transfer happens exactly once, whatever the stall pattern.
- R11: After reset `req_ready`=1, `done`=0, `mem_valid`=0 and `ime_set`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_kind | input | 3 | 0 abs jump, 1 rel jump, 2 call, 3 return, 4 return-from-interrupt, 5 restart, 6 jump to HL |
| req_cond_en | input | 1 | Operation is conditional (kinds 0 to 3 only) |
| req_opcode | input | 8 | Opcode byte: bits 4:3 condition, bits 5:3 restart vector |
| req_imm | input | 16 | Absolute target |
| req_disp | input | 8 | Signed relative displacement |
| req_pc | input | 16 | PC after operand fetch (return address) |
| req_sp | input | 16 | Current stack pointer |
| req_hl | input | 16 | Current HL pair |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| mem_valid | output | 1 | Memory transfer requested |
| mem_ready | input | 1 | Memory accepts or returns data this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | 16 | Resulting PC, valid with done |
| next_sp | output | 16 | Resulting SP, valid with done |
| cycles | output | 3 | Machine cycles charged, valid with done |
| taken | output | 1 | Branch outcome, valid with done |
| ime_set | output | 1 | Set interrupt master enable, with done |

## Verification
The properties assume that the memory side returns read data in the same cycle as `mem_ready`. They also assume that the request fields stay still while `req_valid` waits, and that `mem_ready` can stay low for any number of cycles. The stimulus holds every request field constant from the drive cycle through acceptance. The memory model answers from a byte array indexed by the address, and it is run with no stalls, with every second cycle stalled, and with two of every three cycles stalled. Stack pointers are chosen so that pushes and pops never cross a 256-byte boundary of the model, so the model's index maps one to one onto the addresses the unit produces.

// File: rtl/flow_pkg.sv
package flow_pkg;

  typedef enum logic [2:0] {
    FK_JABS = 3'd0,
    FK_JREL = 3'd1,
    FK_CALL = 3'd2,
    FK_RET  = 3'd3,
    FK_RETI = 3'd4,
    FK_RST  = 3'd5,
    FK_JHL  = 3'd6
  } flow_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PUSH_HI,
    SQ_PUSH_LO,
    SQ_POP_LO,
    SQ_POP_HI,
    SQ_RESP
  } seq_state_e;

  // machine-cycle costs
  localparam int unsigned CY_JABS_T = 4;
  localparam int unsigned CY_JABS_N = 3;
  localparam int unsigned CY_JREL_T = 3;
  localparam int unsigned CY_JREL_N = 2;
  localparam int unsigned CY_CALL_T = 6;
  localparam int unsigned CY_CALL_N = 3;
  localparam int unsigned CY_RETC_T = 5;
  localparam int unsigned CY_RETC_N = 2;
  localparam int unsigned CY_RET_U  = 4;
  localparam int unsigned CY_RETI   = 4;
  localparam int unsigned CY_RST    = 4;
  localparam int unsigned CY_JHL    = 1;

  localparam logic [7:0] RST_VEC_MASK = 8'h38;

endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval (
  input  logic       cond_en,
  input  logic [1:0] cc,
  input  logic       flag_z,
  input  logic       flag_c,
  output logic       take
);
  logic hit;

  always_comb begin
    unique case (cc)
      2'd0:    hit = ~flag_z;
      2'd1:    hit = flag_z;
      2'd2:    hit = ~flag_c;
      default: hit = flag_c;
    endcase
    take = ~cond_en | hit;
  end
endmodule

// File: rtl/flow_target_calc.sv
module flow_target_calc
  import flow_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  flow_kind_e       kind,
  input  logic             take,
  input  logic [DW-1:0]    opcode,
  input  logic [AW-1:0]    imm,
  input  logic [DW-1:0]    disp,
  input  logic [AW-1:0]    pc,
  input  logic [AW-1:0]    hl,
  output logic [AW-1:0]    target
);
  localparam int unsigned EXT_W = AW - DW;

  logic [AW-1:0] disp_ext;
  logic [AW-1:0] rst_vec;

  assign disp_ext = {{EXT_W{disp[DW-1]}}, disp};
  assign rst_vec  = {{EXT_W{1'b0}}, opcode & DW'(RST_VEC_MASK)};

  always_comb begin
    unique case (kind)
      FK_JABS, FK_CALL: target = take ? imm : pc;
      FK_JREL:          target = take ? (pc + disp_ext) : pc;
      FK_RST:           target = rst_vec;
      FK_JHL:           target = hl;
      default:          target = pc;  // returns take the popped word
    endcase
  end
endmodule

// File: rtl/flow_cycle_table.sv
module flow_cycle_table
  import flow_pkg::*;
#(
  parameter int unsigned CYC_W = 3
) (
  input  flow_kind_e       kind,
  input  logic             cond_en,
  input  logic             take,
  output logic [CYC_W-1:0] cycles
);
  always_comb begin
    unique case (kind)
      FK_JABS: cycles = take ? CYC_W'(CY_JABS_T) : CYC_W'(CY_JABS_N);
      FK_JREL: cycles = take ? CYC_W'(CY_JREL_T) : CYC_W'(CY_JREL_N);
      FK_CALL: cycles = take ? CYC_W'(CY_CALL_T) : CYC_W'(CY_CALL_N);
      FK_RET: begin
        if (!cond_en)  cycles = CYC_W'(CY_RET_U);
        else if (take) cycles = CYC_W'(CY_RETC_T);
        else           cycles = CYC_W'(CY_RETC_N);
      end
      FK_RETI: cycles = CYC_W'(CY_RETI);
      FK_RST:  cycles = CYC_W'(CY_RST);
      default: cycles = CYC_W'(CY_JHL);
    endcase
  end
endmodule

// File: rtl/flow_stack_seq.sv
module flow_stack_seq
  import flow_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          do_push,
  input  logic          do_pop,
  input  logic [AW-1:0] push_word,
  input  logic [AW-1:0] sp,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          idle,
  output logic          resp,
  output logic [AW-1:0] pop_word
);
  seq_state_e    state_q, state_d;
  logic [DW-1:0] lo_q, hi_q;
  logic          xfer;

  assign xfer = mem_valid & mem_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (start) begin
          if (do_push)     state_d = SQ_PUSH_HI;
          else if (do_pop) state_d = SQ_POP_LO;
          else             state_d = SQ_RESP;
        end
      end
      SQ_PUSH_HI: if (mem_ready) state_d = SQ_PUSH_LO;
      SQ_PUSH_LO: if (mem_ready) state_d = SQ_RESP;
      SQ_POP_LO:  if (mem_ready) state_d = SQ_POP_HI;
      SQ_POP_HI:  if (mem_ready) state_d = SQ_RESP;
      default:    state_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = sp;
    mem_wdata = '0;
    unique case (state_q)
      SQ_PUSH_HI: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp - AW'(1);
        mem_wdata = push_word[AW-1:DW];
      end
      SQ_PUSH_LO: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp - AW'(2);
        mem_wdata = push_word[DW-1:0];
      end
      SQ_POP_LO: begin
        mem_valid = 1'b1;
        mem_addr  = sp;
      end
      SQ_POP_HI: begin
        mem_valid = 1'b1;
        mem_addr  = sp + AW'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      if (xfer && state_q == SQ_POP_LO) lo_q <= mem_rdata;
      if (xfer && state_q == SQ_POP_HI) hi_q <= mem_rdata;
    end
  end

  assign idle     = (state_q == SQ_IDLE);
  assign resp     = (state_q == SQ_RESP);
  assign pop_word = {hi_q, lo_q};
endmodule

// File: rtl/flow_ctl.sv
module flow_ctl
  import flow_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned CYC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_kind,
  input  logic             req_cond_en,
  input  logic [DW-1:0]    req_opcode,
  input  logic [AW-1:0]    req_imm,
  input  logic [DW-1:0]    req_disp,
  input  logic [AW-1:0]    req_pc,
  input  logic [AW-1:0]    req_sp,
  input  logic [AW-1:0]    req_hl,
  input  logic             flag_z,
  input  logic             flag_c,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             done,
  output logic [AW-1:0]    next_pc,
  output logic [AW-1:0]    next_sp,
  output logic [CYC_W-1:0] cycles,
  output logic             taken,
  output logic             ime_set
);
  localparam logic [AW-1:0] SP_STEP = AW'(2);

  flow_kind_e       kind;
  logic             cond_eff;
  logic             take_d;
  logic [AW-1:0]    target_d;
  logic [CYC_W-1:0] cyc_d;
  logic             push_d, pop_d;
  logic             accept;
  logic             idle;
  logic [AW-1:0]    pop_word;

  logic             take_q, push_q, pop_q, ime_q;
  logic [AW-1:0]    target_q, ret_pc_q, sp_q, nsp_q;
  logic [CYC_W-1:0] cyc_q;

  assign kind     = flow_kind_e'(req_kind);
  assign cond_eff = req_cond_en &
                    (kind == FK_JABS || kind == FK_JREL ||
                     kind == FK_CALL || kind == FK_RET);
  assign accept   = req_valid & req_ready;

  flow_cond_eval u_cond (
    .cond_en (cond_eff),
    .cc      (req_opcode[4:3]),
    .flag_z  (flag_z),
    .flag_c  (flag_c),
    .take    (take_d)
  );

  flow_target_calc #(.AW(AW), .DW(DW)) u_tgt (
    .kind    (kind),
    .take    (take_d),
    .opcode  (req_opcode),
    .imm     (req_imm),
    .disp    (req_disp),
    .pc      (req_pc),
    .hl      (req_hl),
    .target  (target_d)
  );

  flow_cycle_table #(.CYC_W(CYC_W)) u_cyc (
    .kind    (kind),
    .cond_en (cond_eff),
    .take    (take_d),
    .cycles  (cyc_d)
  );

  assign push_d = (kind == FK_RST) | (kind == FK_CALL & take_d);
  assign pop_d  = (kind == FK_RETI) | (kind == FK_RET & take_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q   <= 1'b0;
      push_q   <= 1'b0;
      pop_q    <= 1'b0;
      ime_q    <= 1'b0;
      target_q <= '0;
      ret_pc_q <= '0;
      sp_q     <= '0;
      nsp_q    <= '0;
      cyc_q    <= '0;
    end else if (accept) begin
      take_q   <= take_d;
      push_q   <= push_d;
      pop_q    <= pop_d;
      ime_q    <= (kind == FK_RETI);
      target_q <= target_d;
      ret_pc_q <= req_pc;
      sp_q     <= req_sp;
      cyc_q    <= cyc_d;
      if (push_d)     nsp_q <= req_sp - SP_STEP;
      else if (pop_d) nsp_q <= req_sp + SP_STEP;
      else            nsp_q <= req_sp;
    end
  end

  flow_stack_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .do_push   (push_d),
    .do_pop    (pop_d),
    .push_word (ret_pc_q),
    .sp        (sp_q),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .idle      (idle),
    .resp      (done),
    .pop_word  (pop_word)
  );

  assign req_ready = idle;
  assign next_pc   = pop_q ? pop_word : target_q;
  assign next_sp   = nsp_q;
  assign cycles    = cyc_q;
  assign taken     = take_q;
  assign ime_set   = done & ime_q;
endmodule

// File: rtl/flow_ctl_checks.sv
module flow_ctl_checks #(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned CYC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_wdata,
  input logic             done,
  input logic             taken,
  input logic [CYC_W-1:0] cycles,
  input logic             ime_set
);
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);  // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);  // R9
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid);  // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_we) && $stable(mem_wdata));  // R10
  AST_IME_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ime_set |-> done);  // R6
  AST_NOT_TAKEN_COST: assert property (@(posedge clk) disable iff (!rst_n)
    done && !taken |-> (cycles == CYC_W'(2) || cycles == CYC_W'(3)));  // R2
  AST_NO_MEM_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_valid);  // R10
endmodule

bind flow_ctl flow_ctl_checks #(.AW(AW), .DW(DW), .CYC_W(CYC_W)) u_flow_ctl_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .done      (done),
  .taken     (taken),
  .cycles    (cycles),
  .ime_set   (ime_set)
);

// File: tb/test_flow_ctl.sv
module test_flow_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic        req_cond_en = 1'b0;
  logic [7:0]  req_opcode = '0;
  logic [15:0] req_imm = '0;
  logic [7:0]  req_disp = '0;
  logic [15:0] req_pc = '0;
  logic [15:0] req_sp = '0;
  logic [15:0] req_hl = '0;
  logic        flag_z = 1'b0;
  logic        flag_c = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        done;
  logic [15:0] next_pc;
  logic [15:0] next_sp;
  logic [2:0]  cycles;
  logic        taken;
  logic        ime_set;

  int checks = 0;
  int fails  = 0;
  int stall_mode = 0;
  int tick = 0;

  logic [7:0]  rmem [256];
  logic [15:0] wlog_a [2048];
  logic [7:0]  wlog_d [2048];
  int          wcount = 0;

  always #5 clk = ~clk;

  flow_ctl i_flow_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_cond_en(req_cond_en), .req_opcode(req_opcode),
    .req_imm(req_imm), .req_disp(req_disp), .req_pc(req_pc), .req_sp(req_sp),
    .req_hl(req_hl), .flag_z(flag_z), .flag_c(flag_c), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
    .next_pc(next_pc), .next_sp(next_sp), .cycles(cycles), .taken(taken),
    .ime_set(ime_set)
  );

  assign mem_rdata = rmem[mem_addr[7:0]];

  always @(negedge clk) begin
    tick <= tick + 1;
    if (stall_mode == 0) mem_ready <= 1'b1;
    else                 mem_ready <= ((tick % (stall_mode + 1)) == 0);
  end

  always @(posedge clk) begin
    if (mem_valid && mem_ready && mem_we) begin
      wlog_a[wcount % 2048] = mem_addr;
      wlog_d[wcount % 2048] = mem_wdata;
      wcount = wcount + 1;
    end
  end

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [2:0] kind, input logic cen,
                         input logic [7:0] op, input logic [15:0] imm,
                         input logic [7:0] disp, input logic [15:0] pc,
                         input logic [15:0] sp, input logic [15:0] hl,
                         input logic z, input logic c);
    logic        hit, take, push, pop, ime;
    logic [15:0] exp_pc, exp_sp;
    int          exp_cyc, lat, wbase;
    string       rq;
    logic [7:0]  lo_i, hi_i;

    lo_i = sp[7:0];
    hi_i = lo_i + 8'd1;
    rmem[lo_i] = imm[7:0] ^ 8'h5A;
    rmem[hi_i] = imm[15:8] ^ 8'hC3;

    case (op[4:3])
      2'd0: hit = !z;
      2'd1: hit = z;
      2'd2: hit = !c;
      default: hit = c;
    endcase
    take = (kind <= 3'd3 && cen) ? hit : 1'b1;
    push = 1'b0; pop = 1'b0; ime = 1'b0; exp_pc = pc; exp_cyc = 1;
    case (kind)
      3'd0: begin rq = "R2"; exp_pc = take ? imm : pc; exp_cyc = take ? 4 : 3; end
      3'd1: begin rq = "R3"; exp_pc = take ? pc + {{8{disp[7]}}, disp} : pc;
                  exp_cyc = take ? 3 : 2; end
      3'd2: begin rq = "R4"; exp_pc = take ? imm : pc; exp_cyc = take ? 6 : 3;
                  push = take; end
      3'd3: begin rq = "R5"; pop = take;
                  exp_pc = take ? {rmem[hi_i], rmem[lo_i]} : pc;
                  exp_cyc = cen ? (take ? 5 : 2) : 4; end
      3'd4: begin rq = "R6"; pop = 1'b1; ime = 1'b1;
                  exp_pc = {rmem[hi_i], rmem[lo_i]}; exp_cyc = 4; end
      3'd5: begin rq = "R7"; push = 1'b1; exp_pc = {8'h00, op & 8'h38}; exp_cyc = 4; end
      default: begin rq = "R8"; exp_pc = hl; exp_cyc = 1; end
    endcase
    exp_sp = push ? sp - 16'd2 : (pop ? sp + 16'd2 : sp);

    @(negedge clk);
    wbase = wcount;
    req_kind = kind; req_cond_en = cen; req_opcode = op; req_imm = imm;
    req_disp = disp; req_pc = pc; req_sp = sp; req_hl = hl;
    flag_z = z; flag_c = c; req_valid = 1'b1;
    @(posedge clk);
    lat = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
    end while (!done && lat < 60);

    chk(rq, "done seen", {31'd0, done}, 32'd1);
    chk(rq, "next_pc", {16'd0, next_pc}, {16'd0, exp_pc});
    chk(rq, "next_sp", {16'd0, next_sp}, {16'd0, exp_sp});
    chk(rq, "cycles", {29'd0, cycles}, exp_cyc);
    chk("R1", "taken", {31'd0, taken}, {31'd0, take});
    chk("R6", "ime_set", {31'd0, ime_set}, {31'd0, ime});
    chk("R9", "ready low at done", {31'd0, req_ready}, 32'd0);
    if (!push && !pop) chk("R9", "latency", lat, 1);
    if (push) begin
      chk("R10", "write count", wcount - wbase, 2);
      chk(rq, "push hi addr", {16'd0, wlog_a[wbase % 2048]}, {16'd0, sp - 16'd1});
      chk(rq, "push hi data", {24'd0, wlog_d[wbase % 2048]}, {24'd0, pc[15:8]});
      chk(rq, "push lo addr", {16'd0, wlog_a[(wbase + 1) % 2048]}, {16'd0, sp - 16'd2});
      chk(rq, "push lo data", {24'd0, wlog_d[(wbase + 1) % 2048]}, {24'd0, pc[7:0]});
    end else begin
      chk(rq, "no writes", wcount - wbase, 0);
    end
    @(negedge clk);
    chk("R9", "done dropped", {31'd0, done}, 32'd0);
    chk("R9", "ready back", {31'd0, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) rmem[i] = 8'(i * 29 + 7);
    repeat (4) @(negedge clk);
    chk("R11", "ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R11", "done in reset", {31'd0, done}, 32'd0);
    chk("R11", "mem_valid in reset", {31'd0, mem_valid}, 32'd0);
    chk("R11", "ime in reset", {31'd0, ime_set}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int s = 0; s < 3; s++) begin
      stall_mode = s;
      for (int k = 0; k < 4; k++)
        for (int ce = 0; ce < 2; ce++)
          for (int cc = 0; cc < 4; cc++)
            for (int zc = 0; zc < 4; zc++) begin
              int n;
              n = ((s * 4 + k) * 2 + ce) * 16 + cc * 4 + zc;
              run_req(3'(k), 1'(ce), {3'b110, 2'(cc), 3'b010},
                      16'h4000 + 16'(n * 131), 8'(n * 37 + 3),
                      16'h1200 + 16'(n * 11), 16'hC040 + 16'(zc * 8),
                      16'h9ABC, 1'(zc), 1'(zc >> 1));
            end
    end

    stall_mode = 1;
    // R7: every restart vector, conditions ignored
    for (int v = 0; v < 8; v++)
      run_req(3'd5, 1'b1, {2'b11, 3'(v), 3'b111}, 16'hFFFF, 8'h00,
              16'h2345 + 16'(v), 16'hD020 + 16'(v * 4), 16'h0000, 1'b1, 1'b1);
    // R6: return-from-interrupt ignores a failing condition
    run_req(3'd4, 1'b1, 8'hC0, 16'h1357, 8'h00, 16'h0101, 16'hC0F0, 16'h0, 1'b1, 1'b1);
    stall_mode = 2;
    run_req(3'd4, 1'b0, 8'hD9, 16'hBEEF, 8'h00, 16'h0202, 16'hC010, 16'h0, 1'b0, 1'b0);
    // R8: jump to HL
    stall_mode = 0;
    run_req(3'd6, 1'b1, 8'hE9, 16'h1111, 8'h00, 16'h3333, 16'hC000, 16'hA55A, 1'b1, 1'b1);
    run_req(3'd6, 1'b0, 8'hE9, 16'h0, 8'h00, 16'h0000, 16'hFFF0, 16'h0001, 1'b0, 1'b0);
    // R3: displacement extremes with wraparound
    run_req(3'd1, 1'b0, 8'h18, 16'h0, 8'h80, 16'h0010, 16'hC000, 16'h0, 1'b0, 1'b0);
    run_req(3'd1, 1'b0, 8'h18, 16'h0, 8'h7F, 16'hFFF0, 16'hC000, 16'h0, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule